// File: doc/BRIEF.md
# Section AIS Frame Generator

This block produces the outgoing SONET/SDH frame one byte per clock. In normal operation it forwards a byte-aligned received stream, whose first A1 byte is flagged by a start marker. In AIS operation it discards the received stream and emits a frame that it times itself. That frame has the framing pattern in every A1/A2 slot and all-ones in every other byte. The AIS frame keeps its own frame counter, so its timing does not depend on the receive framer.

In both modes, the 27 first-channel transport overhead bytes can be overwritten from a small register file. Each entry holds a value and a write-inhibit flag. A forced refresh can rewrite the whole A1/A2 boundary, so that downstream equipment stays in frame. During AIS the B2 byte of the first STS-1 is either computed or forced to FFh. The result is then passed through a frame-synchronous scrambler.

The rate select sets the interleave factor N: 3, 12 or 48. A frame has 9 rows of 90·N bytes. Column c of a row belongs to column group c/N and channel c%N. The transport overhead is column groups 0 to 2.

Top module: `sais_frame_gen`

## Requirements
- R1: While AIS is active, every byte in row 0 group 0 is F6h and every byte in row 0 group 1 is 28h. Every other byte is FFh, except where R3, R4 or R5 replace it. This holds before scrambling.
- R2: A change of `ais_en` takes effect only on the byte at which the internal generator counter is at frame start. While AIS is active, `tx_sof` follows the generator counter. Otherwise `tx_sof` follows the receive alignment, where a byte with `rx_sof` high is frame position 0.
- R3: While AIS is active, the byte at row 4, group 0, channel 0 (overhead index 12) is set by `b2_calc_en`. With `b2_calc_en` high it is the XOR of all pre-scramble output bytes of channel 0 in the previous frame, excluding rows 0 to 2 of groups 0 to 2. That XOR is further XORed with the index-12 register value, unless that entry is inhibited. With `b2_calc_en` low the byte is FFh.
- R4: The channel-0 byte at row r and group g < 3 has overhead index 3r+g. If its entry is not inhibited, the byte is replaced by the register value; if it is inhibited, the byte passes unchanged. A write with `oh_we` high takes effect from the next byte. Writes to indices 27 to 31 are ignored. After reset every entry is inhibited.
- R5: With `a1a2_refresh` high, every byte of row 0 group 0 is F6h and every byte of row 0 group 1 is 28h in either mode. This overrides R4.
- R6: Every byte except row 0 groups 0 to 2 is XORed with a keystream from 1+x^6+x^7. Bits are taken MSB first. The generator is reloaded with all ones at row 0, group 3, channel 0, so the keystream there begins FEh, 04h, 18h.
- R7: With `scr_dis` high, no byte is scrambled.
- R8: `rate_sel` codes 0, 1 and 2 select N = 3, 12 and 48, giving frames of 2430, 9720 and 38880 bytes.
- R9: Each output byte appears on `tx_data` one clock after its input byte. `tx_sof` is high for exactly the byte at frame position 0.
- R10: During reset `tx_data` is 00h and `tx_sof` is low.
- R11: In normal mode, a byte outside the replaced overhead equals `rx_data`, scrambled per R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Interleave select: 0 = N 3, 1 = N 12, 2 = N 48 |
| ais_en | input | 1 | Request AIS frame generation |
| b2_calc_en | input | 1 | In AIS, computed B2 (1) or FFh (0) |
| a1a2_refresh | input | 1 | Force the whole A1/A2 boundary |
| scr_dis | input | 1 | Disable scrambling |
| rx_data | input | 8 | Aligned received byte |
| rx_sof | input | 1 | Marks the first A1 byte of a received frame |
| oh_we | input | 1 | Overhead register write strobe |
| oh_addr | input | 5 | Overhead register index |
| oh_data | input | 8 | Overhead register value |
| oh_inh | input | 1 | Write-inhibit flag for the addressed entry |
| tx_data | output | 8 | Outgoing byte |
| tx_sof | output | 1 | Outgoing frame start pulse |

## Verification
A wrong frame position shows at once as a `tx_sof` pulse off its 2430-, 9720- or 38880-byte cadence. It also shows as overhead values landing in the wrong slot within the same frame. A corrupted scrambler state spoils every scrambled byte up to the next reload point, so it is visible within one frame. A bad B2 accumulator appears only at the index-12 slot of the next AIS frame. A misplaced mode switch shows as AIS fill starting somewhere other than at the generator's frame start. The bench therefore compares every output byte and frame pulse against a model in all three rates and across both mode transitions.

// File: rtl/sais_pkg.sv
package sais_pkg;
    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned ROWS     = 9;
    parameter int unsigned GRPS     = 90;
    parameter int unsigned TOH_GRPS = 3;
    parameter int unsigned SOH_ROWS = 3;
    parameter int unsigned MAX_CH   = 48;
    parameter int unsigned B2_ROW   = 4;

    localparam int unsigned OH_NUM = ROWS * TOH_GRPS;
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned GRP_W  = $clog2(GRPS);
    localparam int unsigned CH_W   = $clog2(MAX_CH);
    localparam int unsigned OH_AW  = $clog2(OH_NUM);
    localparam int unsigned B2_IDX = B2_ROW * TOH_GRPS;

    localparam logic [BYTE_W-1:0] A1_PAT   = 8'hF6;
    localparam logic [BYTE_W-1:0] A2_PAT   = 8'h28;
    localparam logic [BYTE_W-1:0] AIS_FILL = 8'hFF;

    typedef enum logic [1:0] {
        RATE_N3  = 2'd0,
        RATE_N12 = 2'd1,
        RATE_N48 = 2'd2,
        RATE_RSV = 2'd3
    } rate_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [GRP_W-1:0] grp;
        logic [CH_W-1:0]  ch;
    } fpos_t;

    function automatic logic [CH_W-1:0] last_ch(input logic [1:0] rate);
        case (rate_e'(rate))
            RATE_N12: return CH_W'(11);
            RATE_N48: return CH_W'(47);
            default:  return CH_W'(2);
        endcase
    endfunction
endpackage

// File: rtl/sais_pos_ctr.sv
module sais_pos_ctr
    import sais_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate,
    input  logic       restart,
    output fpos_t      cur,
    output logic       at_start
);
    typedef struct packed {
        fpos_t nxt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [CH_W-1:0] lc;
        st_d = st_q;
        lc   = last_ch(rate);
        cur  = restart ? '0 : st_q.nxt;
        at_start = (cur == '0);
        if (cur.ch >= lc) begin
            st_d.nxt.ch = '0;
            if (cur.grp >= GRP_W'(GRPS - 1)) begin
                st_d.nxt.grp = '0;
                if (cur.row >= ROW_W'(ROWS - 1)) st_d.nxt.row = '0;
                else                              st_d.nxt.row = cur.row + 1'b1;
            end else begin
                st_d.nxt.grp = cur.grp + 1'b1;
                st_d.nxt.row = cur.row;
            end
        end else begin
            st_d.nxt     = cur;
            st_d.nxt.ch  = cur.ch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sais_scr.sv
module sais_scr
    import sais_pkg::*;
#(
    parameter int unsigned LFSR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [BYTE_W-1:0] key
);
    typedef struct packed {
        logic [BYTE_W-1:0] key;
        logic [LFSR_W-1:0] st;
    } ks_t;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } st_t;

    st_t st_d, st_q;

    function automatic ks_t run_byte(input logic [LFSR_W-1:0] seed);
        ks_t r;
        r.st  = seed;
        r.key = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            r.key[i] = r.st[LFSR_W-1];
            r.st     = {r.st[LFSR_W-2:0], r.st[LFSR_W-1] ^ r.st[LFSR_W-2]};
        end
        return r;
    endfunction

    always_comb begin
        ks_t ks;
        st_d = st_q;
        ks   = run_byte(restart ? '1 : st_q.lfsr);
        key  = ks.key;
        if (restart || advance) st_d.lfsr = ks.st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sais_oh_regs.sv
module sais_oh_regs
    import sais_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OH_AW-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              winh,
    input  logic [OH_AW-1:0]  raddr,
    output logic [BYTE_W-1:0] rdata,
    output logic              rinh
);
    typedef struct packed {
        logic              inh;
        logic [BYTE_W-1:0] val;
    } ohe_t;

    typedef struct packed {
        ohe_t [OH_NUM-1:0] ent;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (waddr < OH_AW'(OH_NUM))) begin
            st_d.ent[waddr].inh = winh;
            st_d.ent[waddr].val = wdata;
        end
        if (raddr < OH_AW'(OH_NUM)) begin
            rdata = st_q.ent[raddr].val;
            rinh  = st_q.ent[raddr].inh;
        end else begin
            rdata = '0;
            rinh  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < OH_NUM; i++) begin
                st_q.ent[i].inh <= 1'b1;
                st_q.ent[i].val <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sais_frame_gen.sv
module sais_frame_gen
    import sais_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              ais_en,
    input  logic              b2_calc_en,
    input  logic              a1a2_refresh,
    input  logic              scr_dis,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              oh_we,
    input  logic [OH_AW-1:0]  oh_addr,
    input  logic [BYTE_W-1:0] oh_data,
    input  logic              oh_inh,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_sof
);
    typedef struct packed {
        logic              ais_hold;
        logic [BYTE_W-1:0] b2_acc;
        logic [BYTE_W-1:0] b2_prev;
        logic [BYTE_W-1:0] tx_data;
        logic              tx_sof;
    } st_t;

    st_t st_d, st_q;

    fpos_t rx_pos, gen_pos, act_pos;
    logic  rx_start, gen_start, act_start;
    logic  ais_cur, is_oh, a1_slot, a2_slot, hdr_toh;
    logic  scr_restart, b2_region, b2_slot;
    logic  [OH_AW-1:0]  oh_idx;
    logic  [BYTE_W-1:0] oh_val, key;
    logic  oh_val_inh;

    // receive-aligned position and free-running generator position
    sais_pos_ctr u_rx_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (rate_sel),
        .restart  (rx_sof),
        .cur      (rx_pos),
        .at_start (rx_start)
    );

    sais_pos_ctr u_gen_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (rate_sel),
        .restart  (1'b0),
        .cur      (gen_pos),
        .at_start (gen_start)
    );

    // position decode
    always_comb begin
        ais_cur     = gen_start ? ais_en : st_q.ais_hold;
        act_pos     = ais_cur ? gen_pos : rx_pos;
        act_start   = ais_cur ? gen_start : rx_start;
        hdr_toh     = (act_pos.row == '0) && (act_pos.grp < GRP_W'(TOH_GRPS));
        is_oh       = (act_pos.grp < GRP_W'(TOH_GRPS)) && (act_pos.ch == '0);
        oh_idx      = OH_AW'(act_pos.row) * OH_AW'(TOH_GRPS) + OH_AW'(act_pos.grp);
        a1_slot     = (act_pos.row == '0) && (act_pos.grp == GRP_W'(0));
        a2_slot     = (act_pos.row == '0) && (act_pos.grp == GRP_W'(1));
        scr_restart = (act_pos.row == '0) && (act_pos.grp == GRP_W'(TOH_GRPS))
                      && (act_pos.ch == '0);
        b2_region   = (act_pos.ch == '0)
                      && !((act_pos.row < ROW_W'(SOH_ROWS)) && (act_pos.grp < GRP_W'(TOH_GRPS)));
        b2_slot     = is_oh && (oh_idx == OH_AW'(B2_IDX));
    end

    sais_oh_regs u_oh_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (oh_we),
        .waddr (oh_addr),
        .wdata (oh_data),
        .winh  (oh_inh),
        .raddr (oh_idx),
        .rdata (oh_val),
        .rinh  (oh_val_inh)
    );

    sais_scr #(.LFSR_W(7)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (scr_restart),
        .advance (!hdr_toh),
        .key     (key)
    );

    // next state
    always_comb begin
        logic [BYTE_W-1:0] base, pre;
        st_d = st_q;
        st_d.ais_hold = ais_cur;

        if (ais_cur) begin
            if (a1_slot)      base = A1_PAT;
            else if (a2_slot) base = A2_PAT;
            else              base = AIS_FILL;
        end else begin
            base = rx_data;
        end

        pre = base;
        if (is_oh && !oh_val_inh) pre = oh_val;
        if (ais_cur && b2_slot) begin
            if (b2_calc_en) pre = st_q.b2_prev ^ (oh_val_inh ? '0 : oh_val);
            else            pre = AIS_FILL;
        end
        if (a1a2_refresh && a1_slot) pre = A1_PAT;
        if (a1a2_refresh && a2_slot) pre = A2_PAT;

        if (act_start) begin
            st_d.b2_prev = st_q.b2_acc;
            st_d.b2_acc  = '0;
        end else if (b2_region) begin
            st_d.b2_acc  = st_q.b2_acc ^ pre;
        end

        st_d.tx_data = (scr_dis || hdr_toh) ? pre : (pre ^ key);
        st_d.tx_sof  = act_start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_data = st_q.tx_data;
    assign tx_sof  = st_q.tx_sof;
endmodule

// File: rtl/sais_frame_gen_chk.sv
module sais_frame_gen_chk
    import sais_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_sof,
    input logic              a1a2_refresh,
    input logic              b2_calc_en,
    input logic              scr_dis,
    input logic              ais_cur,
    input logic              ais_hold,
    input logic              gen_start,
    input fpos_t             act_pos,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_sof
);
    p_sof_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> ($past(act_pos) == fpos_t'(0)));

    p_mode_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ais_hold) |-> $past(gen_start));

    p_rx_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ais_cur && rx_sof) |=> tx_sof);

    p_ais_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_cur && scr_dis && (act_pos.grp >= GRP_W'(TOH_GRPS))) |=> (tx_data == AIS_FILL));

    p_b2_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_cur && !b2_calc_en && scr_dis && (act_pos.row == ROW_W'(B2_ROW))
         && (act_pos.grp == '0) && (act_pos.ch == '0)) |=> (tx_data == AIS_FILL));

    p_a1_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a1a2_refresh && (act_pos.row == '0) && (act_pos.grp == '0)) |=> (tx_data == A1_PAT));

    p_a2_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a1a2_refresh && (act_pos.row == '0) && (act_pos.grp == GRP_W'(1))) |=> (tx_data == A2_PAT));
endmodule

bind sais_frame_gen sais_frame_gen_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_sof       (rx_sof),
    .a1a2_refresh (a1a2_refresh),
    .b2_calc_en   (b2_calc_en),
    .scr_dis      (scr_dis),
    .ais_cur      (ais_cur),
    .ais_hold     (st_q.ais_hold),
    .gen_start    (gen_start),
    .act_pos      (act_pos),
    .tx_data      (tx_data),
    .tx_sof       (tx_sof)
);

// File: tb/test_sais_frame_gen.sv
module test_sais_frame_gen;
    localparam int CLK_PERIOD = 10;
    localparam int RX_OFF     = 137;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       ais_en = 1'b0, b2_calc_en = 1'b0, a1a2_refresh = 1'b0, scr_dis = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rx_sof = 1'b0;
    logic       oh_we = 1'b0;
    logic [4:0] oh_addr = 5'd0;
    logic [7:0] oh_data = 8'h00;
    logic       oh_inh = 1'b0;
    logic [7:0] tx_data;
    logic       tx_sof;

    always #(CLK_PERIOD/2) clk = ~clk;

    sais_frame_gen i_sais_frame_gen (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ais_en(ais_en),
        .b2_calc_en(b2_calc_en), .a1a2_refresh(a1a2_refresh), .scr_dis(scr_dis),
        .rx_data(rx_data), .rx_sof(rx_sof), .oh_we(oh_we), .oh_addr(oh_addr),
        .oh_data(oh_data), .oh_inh(oh_inh), .tx_data(tx_data), .tx_sof(tx_sof)
    );

    typedef struct packed {
        logic [47:0] req;
        logic [31:0] stamp;
        logic [7:0]  d;
        logic        sof;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    // shadow controls, applied by step() together with the byte they govern
    logic [1:0] v_rate = 2'd0;
    bit v_ais = 0, v_b2c = 1, v_force = 0, v_scrdis = 1;
    bit w_we = 0, w_inh = 0;
    int w_addr = 0;
    logic [7:0] w_data = 0;

    // reference model state
    int m_gen, m_rx, m_lin;
    bit m_hold;
    bit m_inh[27];
    logic [7:0] m_val[27];
    logic [7:0] m_acc, m_prev;
    int m_lfsr;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each output byte one cycle after it was driven
    always @(negedge clk) begin
        if (q.size() > 0 && int'(q[0].stamp) == cyc - 1) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (tx_data !== e.d || tx_sof !== e.sof) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual data=%02h sof=%0b expected data=%02h sof=%0b",
                         e.req, cyc, tx_data, tx_sof, e.d, e.sof);
            end
        end
    end

    task automatic model_reset();
        m_gen = 0; m_rx = 0; m_lin = 0; m_hold = 0;
        m_acc = 0; m_prev = 0; m_lfsr = 7'h7f;
        for (int i = 0; i < 27; i++) begin m_inh[i] = 1; m_val[i] = 8'h00; end
    endtask

    function automatic int n_of(input logic [1:0] r);
        return (r == 2'd1) ? 12 : (r == 2'd2) ? 48 : 3;
    endfunction

    task automatic step(input logic [7:0] rxd, input bit sof);
        int n, fl, rw, gcur, rcur, p, row, col, grp, ch, k;
        bit ais, hdr;
        logic [7:0] base, pre, kst, outb;
        logic [47:0] req;
        exp_t e;
        @(negedge clk);
        n = n_of(v_rate); fl = 810 * n; rw = 90 * n;
        gcur = m_gen; m_gen = (gcur + 1) % fl;
        rcur = sof ? 0 : m_rx; m_rx = (rcur + 1) % fl;
        ais = (gcur == 0) ? v_ais : m_hold; m_hold = ais;
        p = ais ? gcur : rcur;
        row = p / rw; col = p % rw; grp = col / n; ch = col % n;
        req = "R11";
        if (ais) begin
            req = "R1";
            base = (row == 0 && grp == 0) ? 8'hF6 : (row == 0 && grp == 1) ? 8'h28 : 8'hFF;
        end else base = rxd;
        pre = base;
        k = row * 3 + grp;
        if (grp < 3 && ch == 0 && !m_inh[k]) begin pre = m_val[k]; req = "R4"; end
        if (ais && grp < 3 && ch == 0 && k == 12) begin
            req = "R3";
            pre = v_b2c ? (m_prev ^ (m_inh[12] ? 8'h00 : m_val[12])) : 8'hFF;
        end
        if (v_force && row == 0 && grp < 2) begin
            pre = (grp == 0) ? 8'hF6 : 8'h28; req = "R5";
        end
        hdr = (row == 0 && grp < 3);
        kst = 8'h00;
        if (row == 0 && grp == 3 && ch == 0) m_lfsr = 7'h7f;
        if (!hdr) begin
            for (int b = 7; b >= 0; b--) begin
                int fb;
                kst[b] = 1'((m_lfsr >> 6) & 1);
                fb = ((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1;
                m_lfsr = ((m_lfsr << 1) | fb) & 8'h7f;
            end
            if (req == "R11" || req == "R1") req = v_scrdis ? "R7" : "R6";
        end
        outb = (v_scrdis || hdr) ? pre : (pre ^ kst);
        if (p == 0) begin
            m_prev = m_acc; m_acc = 8'h00;
            req = (n != 3) ? "R8" : (ais ? "R2" : "R9");
        end else if (ch == 0 && !(row < 3 && grp < 3)) m_acc = m_acc ^ pre;
        e.req = req; e.stamp = 32'(cyc); e.d = outb; e.sof = (p == 0);
        q.push_back(e);
        rst_n = 1'b1;
        rate_sel = v_rate; ais_en = v_ais; b2_calc_en = v_b2c;
        a1a2_refresh = v_force; scr_dis = v_scrdis;
        rx_data = rxd; rx_sof = sof;
        oh_we = w_we; oh_addr = 5'(w_addr); oh_data = w_data; oh_inh = w_inh;
        if (w_we && w_addr < 27) begin m_inh[w_addr] = w_inh; m_val[w_addr] = w_data; end
        w_we = 0;
    endtask

    task automatic run_bytes(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            int fl;
            fl = 810 * n_of(v_rate);
            step(8'(m_lin * 29 + 7), (m_lin % fl) == RX_OFF);
            m_lin++;
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d, input bit inh);
        w_we = 1; w_addr = a; w_data = d; w_inh = inh;
        run_bytes(1);
    endtask

    task automatic do_reset(input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        q.delete();
        n_chk++;
        if (tx_data !== 8'h00 || tx_sof !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: actual data=%02h sof=%0b expected data=00 sof=0", tx_data, tx_sof);
        end
        v_rate = r;
        model_reset();
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog: actual run still busy, expected completion");
        wrap_up();
    end

    initial begin
        // R10: reset values
        do_reset(2'd0);
        // R11, R9: plain forwarding, all entries inhibited
        run_bytes(2500);
        // R4: overhead replacement, inhibited write, ignored address
        wr(0, 8'h5A, 0); wr(1, 8'h99, 0); wr(2, 8'h01, 0); wr(4, 8'h3C, 0);
        wr(12, 8'h00, 0); wr(13, 8'hC3, 0); wr(26, 8'hA5, 0);
        wr(29, 8'h77, 0); wr(7, 8'h11, 1);
        run_bytes(2500);
        // R6: scrambling on
        v_scrdis = 0;
        run_bytes(2500);
        // R5: forced A1/A2 refresh
        v_force = 1;
        run_bytes(2500);
        v_force = 0;
        // R1, R2, R3: AIS with computed B2, then with a mask
        v_ais = 1;
        run_bytes(5000);
        wr(12, 8'h81, 0);
        run_bytes(2500);
        // R3: forced B2, then R7 with scrambling off
        v_b2c = 0;
        run_bytes(2500);
        v_scrdis = 1;
        run_bytes(2500);
        // R2: back to normal at the generator boundary
        v_ais = 0; v_scrdis = 0;
        run_bytes(3000);
        // R8: N = 12 in AIS
        do_reset(2'd1);
        v_ais = 1; v_b2c = 1;
        wr(3, 8'h6E, 0); wr(25, 8'h42, 0);
        run_bytes(19600);
        // R8: N = 48 in normal mode with refresh
        do_reset(2'd2);
        v_ais = 0; v_force = 1;
        wr(5, 8'hD2, 0);
        run_bytes(39500);
        repeat (3) @(negedge clk);
        wrap_up();
    end
endmodule